// File: doc/BRIEF.md
# Nibble-coded I2C bit sequencer

This block is an I2C master that does not understand bytes or transactions. It executes a program of 4-bit pin-level opcodes held in a local byte-wide RAM. Each opcode either moves one bus line, waits, or runs one complete bit slot (set SDA, raise SCL, lower SCL). During the high half of a slot it may sample SDA or check an acknowledge. The host loads the program through a byte port, writes a control word with a start flag and a nibble address, and polls a status word. Received bytes are written back into the same RAM from byte 0 upward, where the host collects them once the run is over.

Both bus outputs are open-drain style: a 1 releases the line and a 0 pulls it low. The returned SDA level passes through a two-flop synchroniser before it is used. Timing comes from a quarter-bit prescaler (`QUARTER` clock cycles). A pause opcode lasts `PAUSE_BITS` whole bit periods.

Top module: `i2c_nibble_seq`

## Requirements
- R1: A RAM byte holds two opcodes. Nibble address N selects byte N/2: the low nibble when N is even, the high nibble when N is odd. Execution runs through ascending nibble addresses, so the low half of a byte runs before its high half.
- R2: A control write with bit 16 set, made while idle, starts execution at the nibble address in control bits [ADDR_W:0]. Status bit 0 reads 1 from the next cycle on. A start request made while a run is in progress has no effect.
- R3: A control write with bit 17 set aborts any run. In the next cycle status reads 0x8 and both lines are released. When bits 16 and 17 are set together, the abort wins.
- R4: After rst_n is released, status reads 0x8 (bit 3 = no sequence run since reset) and both lines are released. Bit 3 clears when a run starts.
- R5: Every opcode takes 2 cycles to fetch and decode. Opcode 2 drives SCL low, 3 releases SCL, 4 drives SDA low and 5 releases SDA. Each of them then holds for QUARTER cycles.
- R6: Opcodes 8 to 15 run a bit slot. SDA is set from opcode bit 2. SCL is then low for QUARTER cycles, high for 2*QUARTER cycles and low again for QUARTER cycles. SDA does not change while SCL is high within the slot.
- R7: Opcode 13 samples the synchronised SDA at the end of the first high quarter. Samples are shifted in MSB first. Each 8th sample writes the byte into RAM at offsets 0, 1, 2 and so on, and the offset restarts at 0 on every start.
- R8: Opcode 14 sets status bit 1 if the sampled SDA is 1. Opcode 15 sets status bit 2 if the sampled SDA is 0. Both bits are sticky until the next start or abort, and the run carries on after either one is set.
- R9: Opcodes 1 and 6 do nothing beyond their 2 fetch cycles. Opcode 7 holds both lines for PAUSE_BITS*4*QUARTER cycles.
- R10: Opcode 0 ends the run: status bit 0 drops in the cycle after its decode, and both lines keep their last levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word: bit 17 abort, bit 16 start, low bits nibble address |
| stat_o | output | 32 | Status: bit 0 running, bits 2:1 acknowledge errors, bit 3 no run yet |
| mem_we | input | 1 | Host RAM write strobe |
| mem_addr | input | ADDR_W | Host RAM byte address |
| mem_wdata | input | 8 | Host RAM write data |
| mem_rdata | output | 8 | Host RAM read data, one cycle after the address |
| sda_i | input | 1 | Level seen on the SDA line |
| scl_o | output | 1 | SCL drive: 0 pulls low, 1 releases |
| sda_o | output | 1 | SDA drive: 0 pulls low, 1 releases |

## Verification
The bench runs several kinds of program. A plain write of two bytes that both get an acknowledge tells apart slot shape and line timing. The same write with a missing second acknowledge, loaded at an odd nibble address, tells apart error capture and low-before-high nibble order. A read of two bytes against a target that returns 0x5A and 0xC3 shows bit order and where the bytes land. A program made of no-ops, a pause and both acknowledge checks separates the polarity of the two error bits. Runs that are hit by a second start or by an abort halfway through show that a start is ignored while busy and that the abort releases the bus.

// File: rtl/i2cseq_pkg.sv
// Shared constants and types of the nibble-coded I2C sequencer.
// Assumes 4-bit opcodes; values 9..11 behave as bit slots via bit 3.
package i2cseq_pkg;

    localparam logic [3:0] OPC_END    = 4'd0;
    localparam logic [3:0] OPC_MARK   = 4'd1;
    localparam logic [3:0] OPC_SCL_LO = 4'd2;
    localparam logic [3:0] OPC_SCL_HI = 4'd3;
    localparam logic [3:0] OPC_SDA_LO = 4'd4;
    localparam logic [3:0] OPC_SDA_HI = 4'd5;
    localparam logic [3:0] OPC_CLR    = 4'd6;
    localparam logic [3:0] OPC_PAUSE  = 4'd7;

    // action in the high half of a bit slot (opcode bits 1:0)
    localparam logic [1:0] ACT_NONE = 2'd0;
    localparam logic [1:0] ACT_RD   = 2'd1;
    localparam logic [1:0] ACT_CK0  = 2'd2;
    localparam logic [1:0] ACT_CK1  = 2'd3;

    // control word bit positions
    localparam int CTL_START_BIT = 16;
    localparam int CTL_ABORT_BIT = 17;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_HOLD,
        ST_SLOT
    } seq_state_t;

endpackage

// File: rtl/i2cseq_ram.sv
// Byte RAM with a host port (A) and an engine port (B).
// Both ports have registered reads. If both ports write the same
// address in one cycle, the engine write wins.
module i2cseq_ram #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [7:0]    a_wdata,
    output logic [7:0]    a_rdata,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [7:0]    b_wdata,
    output logic [7:0]    b_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    // write from either port, engine first; read both ports
    always_ff @(posedge clk) begin : ram_access
        if (b_we) begin
            mem[b_addr] <= b_wdata;
        end
        if (a_we && !(b_we && b_addr == a_addr)) begin
            mem[a_addr] <= a_wdata;
        end
        a_rdata <= mem[a_addr];
        b_rdata <= mem[b_addr];
    end
endmodule

// File: rtl/i2cseq_tick.sv
// Countdown timer for quarter-bit and pause intervals.
// A load with value V gives V+1 cycles until done; it then rests at zero.
module i2cseq_tick #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    // load or count down to zero
    always_ff @(posedge clk) begin : tick_count
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/i2cseq_rxbyte.sv
// Collects sampled read bits MSB first. After each 8th bit it issues a
// one-cycle RAM write at the current pointer and then advances the pointer.
// Assumes the next sample arrives more than one cycle after a commit.
module i2cseq_rxbyte #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          sample_en,
    input  logic          sample_bit,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data
);
    localparam logic [AW-1:0] PTR_ONE = 1;

    logic [7:0]    shreg_q;
    logic [2:0]    cnt_q;
    logic          full_q;
    logic [AW-1:0] ptr_q;

    // shift in samples, flag a complete byte, advance after commit
    always_ff @(posedge clk) begin : rx_collect
        if (!rst_n || clear) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            full_q  <= 1'b0;
            ptr_q   <= '0;
        end else begin
            if (full_q) begin
                full_q <= 1'b0;
                ptr_q  <= ptr_q + PTR_ONE;
            end
            if (sample_en) begin
                shreg_q <= {shreg_q[6:0], sample_bit};
                cnt_q   <= cnt_q + 3'd1;
                if (cnt_q == 3'd7) begin
                    full_q <= 1'b1;
                end
            end
        end
    end

    assign wr_en   = full_q;
    assign wr_addr = ptr_q;
    assign wr_data = shreg_q;

    AST_RX_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(sample_en)) else $error("byte commit without sample"); // R7
endmodule

// File: rtl/i2cseq_core.sv
// Fetch/decode/execute engine. It reads one byte per opcode, picks the
// nibble with pointer bit 0 and drives the SCL/SDA registers. Assumes
// QUARTER >= 3, so that the synchronised SDA is settled at sample time.
module i2cseq_core
    import i2cseq_pkg::*;
#(
    parameter int NW         = 7,
    parameter int QUARTER    = 4,
    parameter int PAUSE_BITS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_req,
    input  logic          soft_rst,
    input  logic [NW-1:0] start_nib,
    output logic [NW-2:0] fetch_addr,
    input  logic [7:0]    fetch_data,
    input  logic          sda_in,
    output logic          scl_o,
    output logic          sda_o,
    output logic          busy,
    output logic [1:0]    err,
    output logic          no_seq,
    output logic          sample_en,
    output logic          sample_bit,
    output logic          rx_clear
);
    localparam int PAUSE_CYC = PAUSE_BITS * 4 * QUARTER;
    localparam int CW        = $clog2(PAUSE_CYC + 1);
    localparam logic [NW-1:0] NP_ONE = 1;

    seq_state_t    state_q;
    logic [NW-1:0] np_q;
    logic [1:0]    act_q;
    logic [1:0]    phase_q;
    logic          scl_q, sda_q, busy_q, noseq_q;
    logic [1:0]    err_q;
    logic [1:0]    sync_q;
    logic [3:0]    cur_op;
    logic          tick_load, tick_done;
    logic [CW-1:0] tick_val;
    logic          sda_s;

    assign cur_op     = np_q[0] ? fetch_data[7:4] : fetch_data[3:0];
    assign fetch_addr = np_q[NW-1:1];
    assign sda_s      = sync_q[1];

    // bring the external SDA level into the clock domain
    always_ff @(posedge clk) begin : sda_sync
        if (!rst_n) begin
            sync_q <= 2'b11;
        end else begin
            sync_q <= {sync_q[0], sda_in};
        end
    end

    // choose when and with what the interval timer is loaded
    always_comb begin : tick_ctrl
        tick_load = 1'b0;
        tick_val  = CW'(QUARTER - 1);
        if (state_q == ST_DECODE) begin
            if (cur_op[3] || (cur_op >= OPC_SCL_LO && cur_op <= OPC_SDA_HI)) begin
                tick_load = 1'b1;
            end else if (cur_op == OPC_PAUSE) begin
                tick_load = 1'b1;
                tick_val  = CW'(PAUSE_CYC - 1);
            end
        end else if (state_q == ST_SLOT && tick_done && phase_q != 2'd3) begin
            tick_load = 1'b1;
        end
    end

    i2cseq_tick #(.CW(CW)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tick_load),
        .load_val (tick_val),
        .done     (tick_done)
    );

    // sequence state, bus lines, pointer and error flags
    always_ff @(posedge clk) begin : seq_main
        if (!rst_n || soft_rst) begin
            state_q <= ST_IDLE;
            np_q    <= '0;
            act_q   <= ACT_NONE;
            phase_q <= 2'd0;
            scl_q   <= 1'b1;
            sda_q   <= 1'b1;
            busy_q  <= 1'b0;
            noseq_q <= 1'b1;
            err_q   <= 2'b00;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_req) begin
                        np_q    <= start_nib;
                        busy_q  <= 1'b1;
                        err_q   <= 2'b00;
                        noseq_q <= 1'b0;
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: state_q <= ST_DECODE;
                ST_DECODE: begin
                    act_q <= cur_op[1:0];
                    if (cur_op[3]) begin
                        sda_q   <= cur_op[2];
                        scl_q   <= 1'b0;
                        phase_q <= 2'd0;
                        state_q <= ST_SLOT;
                    end else begin
                        case (cur_op)
                            OPC_END: begin
                                busy_q  <= 1'b0;
                                state_q <= ST_IDLE;
                            end
                            OPC_SCL_LO: begin
                                scl_q   <= 1'b0;
                                state_q <= ST_HOLD;
                            end
                            OPC_SCL_HI: begin
                                scl_q   <= 1'b1;
                                state_q <= ST_HOLD;
                            end
                            OPC_SDA_LO: begin
                                sda_q   <= 1'b0;
                                state_q <= ST_HOLD;
                            end
                            OPC_SDA_HI: begin
                                sda_q   <= 1'b1;
                                state_q <= ST_HOLD;
                            end
                            OPC_PAUSE: state_q <= ST_HOLD;
                            default: begin
                                np_q    <= np_q + NP_ONE;
                                state_q <= ST_FETCH;
                            end
                        endcase
                    end
                end
                ST_HOLD: begin
                    if (tick_done) begin
                        np_q    <= np_q + NP_ONE;
                        state_q <= ST_FETCH;
                    end
                end
                ST_SLOT: begin
                    if (tick_done) begin
                        phase_q <= phase_q + 2'd1;
                        case (phase_q)
                            2'd0: scl_q <= 1'b1;
                            2'd1: begin
                                if (act_q == ACT_CK0 && sda_s) begin
                                    err_q[0] <= 1'b1;
                                end
                                if (act_q == ACT_CK1 && !sda_s) begin
                                    err_q[1] <= 1'b1;
                                end
                            end
                            2'd2: scl_q <= 1'b0;
                            default: begin
                                np_q    <= np_q + NP_ONE;
                                state_q <= ST_FETCH;
                            end
                        endcase
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign sample_en  = (state_q == ST_SLOT) && (phase_q == 2'd1) && tick_done
                        && (act_q == ACT_RD) && !soft_rst;
    assign sample_bit = sda_s;
    assign rx_clear   = soft_rst || (state_q == ST_IDLE && start_req);

    assign scl_o  = scl_q;
    assign sda_o  = sda_q;
    assign busy   = busy_q;
    assign err    = err_q;
    assign no_seq = noseq_q;

    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> ($past(start_req) && $past(state_q) == ST_IDLE)) else $error("run began without start"); // R2
    AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!busy_q && scl_q && sda_q && noseq_q)) else $error("abort left bus held"); // R3
    AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLOT && $past(state_q) == ST_SLOT && scl_q && $past(scl_q)) |-> $stable(sda_q)) else $error("SDA moved with SCL high"); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q != 2'b00 && !soft_rst && !(state_q == ST_IDLE && start_req)) |=> (err_q != 2'b00)) else $error("error flag lost"); // R8
    AST_END_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE && cur_op == OPC_END && !soft_rst) |=> !busy_q) else $error("end did not stop run"); // R10
endmodule

// File: rtl/i2c_nibble_seq.sv
// Top of the nibble-coded I2C sequencer: control word decode, status
// word, shared command/data RAM, bit engine and read-byte collector.
// Assumes ADDR_W + 1 <= 16, so the nibble address stays below the start bit.
module i2c_nibble_seq
    import i2cseq_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int QUARTER    = 4,
    parameter int PAUSE_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [31:0]       ctl_wdata,
    output logic [31:0]       stat_o,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_wdata,
    output logic [7:0]        mem_rdata,
    input  logic              sda_i,
    output logic              scl_o,
    output logic              sda_o
);
    localparam int NW = ADDR_W + 1;

    logic              start_req, soft_rst;
    logic [ADDR_W-1:0] fetch_addr, rx_addr, eng_addr;
    logic [7:0]        eng_rdata, rx_data;
    logic              rx_we, busy, no_seq, sample_en, sample_bit, rx_clear;
    logic [1:0]        err;
    logic              unused_ctl;

    assign start_req  = ctl_we && ctl_wdata[CTL_START_BIT];
    assign soft_rst   = ctl_we && ctl_wdata[CTL_ABORT_BIT];
    assign unused_ctl = ^{ctl_wdata[31:18], ctl_wdata[15:NW]};

    assign eng_addr = rx_we ? rx_addr : fetch_addr;

    i2cseq_ram #(.AW(ADDR_W)) u_ram (
        .clk     (clk),
        .a_we    (mem_we),
        .a_addr  (mem_addr),
        .a_wdata (mem_wdata),
        .a_rdata (mem_rdata),
        .b_we    (rx_we),
        .b_addr  (eng_addr),
        .b_wdata (rx_data),
        .b_rdata (eng_rdata)
    );

    i2cseq_core #(
        .NW         (NW),
        .QUARTER    (QUARTER),
        .PAUSE_BITS (PAUSE_BITS)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .soft_rst   (soft_rst),
        .start_nib  (ctl_wdata[NW-1:0]),
        .fetch_addr (fetch_addr),
        .fetch_data (eng_rdata),
        .sda_in     (sda_i),
        .scl_o      (scl_o),
        .sda_o      (sda_o),
        .busy       (busy),
        .err        (err),
        .no_seq     (no_seq),
        .sample_en  (sample_en),
        .sample_bit (sample_bit),
        .rx_clear   (rx_clear)
    );

    i2cseq_rxbyte #(.AW(ADDR_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (rx_clear),
        .sample_en  (sample_en),
        .sample_bit (sample_bit),
        .wr_en      (rx_we),
        .wr_addr    (rx_addr),
        .wr_data    (rx_data)
    );

    assign stat_o = {28'd0, no_seq, err, busy};

    AST_FETCH_NOT_IN_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_we |-> !start_req || busy) else $error("byte commit outside a run"); // R7
endmodule

// File: tb/test_i2c_nibble_seq.sv
module test_i2c_nibble_seq;
    localparam int AW  = 6;
    localparam int Q   = 4;
    localparam int PB  = 2;
    localparam int SLP = PB * 4 * Q;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_we = 1'b0;
    logic [31:0]   ctl_wdata = '0;
    logic [31:0]   stat_o;
    logic          mem_we = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic [7:0]    mem_wdata = '0;
    logic [7:0]    mem_rdata;
    logic          sda_i;
    logic          scl_o, sda_o;

    int total = 0;
    int bad = 0;

    // bench-side target and model state
    bit          slave_bit = 1'b1;
    bit          prev_scl = 1'b1;
    bit          slave_q[$];
    bit          mslave_q[$];
    bit          mslv = 1'b1;
    bit          mscl = 1'b1;
    bit          msda = 1'b1;
    logic [2:0]  expq[$];
    logic [7:0]  exp_rx[$];
    logic [1:0]  exp_err;
    logic [3:0]  nibs[$];
    logic [7:0]  img [64];

    always #4 clk = ~clk;

    assign sda_i = sda_o & slave_bit;

    i2c_nibble_seq #(.ADDR_W(AW), .QUARTER(Q), .PAUSE_BITS(PB)) i_i2c_nibble_seq (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .stat_o(stat_o), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .sda_i(sda_i),
        .scl_o(scl_o), .sda_o(sda_o)
    );

    // target: on each observed SCL fall, present the next queued bit
    always @(negedge clk) begin
        if (prev_scl && !scl_o) begin
            slave_bit = (slave_q.size() > 0) ? slave_q.pop_front() : 1'b1;
        end
        prev_scl = scl_o;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    task automatic mpush(input bit b, input int n);
        for (int i = 0; i < n; i++) expq.push_back({b, mscl, msda});
    endtask

    task automatic mfall();
        if (mscl) mslv = (mslave_q.size() > 0) ? mslave_q.pop_front() : 1'b1;
        mscl = 1'b0;
    endtask

    // behavioural reference: expected {running, scl, sda} per cycle
    task automatic predict(input int start);
        int nib;
        int mbit;
        logic [7:0] macc;
        logic [7:0] v;
        logic [3:0] op;
        bit s;
        nib = start; mbit = 0; macc = 0; exp_err = 2'b00;
        exp_rx.delete(); expq.delete();
        for (int guard = 0; guard < 128; guard++) begin
            v  = img[nib / 2];
            op = (nib % 2 == 1) ? v[7:4] : v[3:0];
            mpush(1'b1, 2);
            if (op == 4'd0) begin
                mpush(1'b0, 1);
                break;
            end else if (op[3]) begin
                msda = op[2];
                mfall(); mpush(1'b1, Q);
                mscl = 1'b1; mpush(1'b1, Q);
                s = msda & mslv;
                case (op[1:0])
                    2'd1: begin
                        macc = {macc[6:0], s}; mbit++;
                        if (mbit == 8) begin exp_rx.push_back(macc); mbit = 0; end
                    end
                    2'd2: if (s) exp_err[0] = 1'b1;
                    2'd3: if (!s) exp_err[1] = 1'b1;
                    default: ;
                endcase
                mpush(1'b1, Q);
                mfall(); mpush(1'b1, Q);
            end else begin
                case (op)
                    4'd2: begin mfall(); mpush(1'b1, Q); end
                    4'd3: begin mscl = 1'b1; mpush(1'b1, Q); end
                    4'd4: begin msda = 1'b0; mpush(1'b1, Q); end
                    4'd5: begin msda = 1'b1; mpush(1'b1, Q); end
                    4'd7: mpush(1'b1, SLP);
                    default: ;
                endcase
            end
            nib = (nib + 1) % 128;
        end
    endtask

    task automatic mem_write(input int a, input logic [7:0] d);
        @(negedge clk);
        mem_we = 1'b1; mem_addr = AW'(a); mem_wdata = d;
        @(negedge clk);
        mem_we = 1'b0;
    endtask

    task automatic mem_read(input int a, output logic [7:0] d);
        @(negedge clk);
        mem_addr = AW'(a);
        @(negedge clk);
        d = mem_rdata;
    endtask

    task automatic put(input logic [3:0] o);
        nibs.push_back(o);
    endtask

    task automatic put_begin();
        put(4'd5); put(4'd3); put(4'd4); put(4'd2);
    endtask

    task automatic put_wbyte(input logic [7:0] val, input logic [3:0] ackop);
        for (int i = 7; i >= 0; i--) put(val[i] ? 4'd12 : 4'd8);
        put(ackop);
    endtask

    task automatic put_rbyte(input bit last);
        for (int i = 0; i < 8; i++) put(4'd13);
        put(last ? 4'd12 : 4'd8);
    endtask

    task automatic put_finish();
        put(4'd4); put(4'd3); put(4'd5); put(4'd0);
    endtask

    // place queued opcodes from nibble base (R1 packing) and write the RAM
    task automatic load(input int base);
        int n;
        int last;
        n = nibs.size();
        last = base + n - 1;
        for (int i = 0; i < n; i++) begin
            if ((base + i) % 2 == 1) img[(base + i) / 2][7:4] = nibs[i];
            else                     img[(base + i) / 2][3:0] = nibs[i];
        end
        for (int b = base / 2; b <= last / 2; b++) mem_write(b, img[b]);
        nibs.delete();
    endtask

    task automatic set_slave(input bit bits[$]);
        slave_q = bits; mslave_q = bits;
        slave_bit = 1'b1; mslv = 1'b1;
    endtask

    // start a run and compare pins/running each cycle; optional injection
    task automatic run(input int start, input int inj, input bit abort, input string tag);
        logic [2:0] e;
        logic [7:0] d;
        int k;
        predict(start);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = 32'h0001_0000 | start;
        @(negedge clk);
        ctl_we = 1'b0;
        k = 0;
        while (expq.size() > 0) begin
            if (abort && k == inj) begin
                ctl_we = 1'b1; ctl_wdata = 32'h0002_0000;
                @(negedge clk);
                ctl_we = 1'b0;
                chk(stat_o == 32'h8 && scl_o && sda_o, "R3 abort mid-run",
                    {stat_o[3:0], scl_o, sda_o}, {4'h8, 2'b11});
                mscl = 1'b1; msda = 1'b1; expq.delete();
                return;
            end
            if (!abort && k == inj) begin
                ctl_we = 1'b1; ctl_wdata = 32'h0001_0000;
            end else begin
                ctl_we = 1'b0;
            end
            e = expq.pop_front();
            chk({stat_o[0], scl_o, sda_o} == e, {tag, " R2 R5 R6 R9 R10 per-cycle"},
                {stat_o[0], scl_o, sda_o}, e);
            k++;
            @(negedge clk);
        end
        ctl_we = 1'b0;
        chk(stat_o[3:0] == {1'b0, exp_err, 1'b0}, {tag, " R8 final status"},
            stat_o[3:0], {1'b0, exp_err, 1'b0});
        for (int i = 0; i < exp_rx.size(); i++) begin
            mem_read(i, d);
            chk(d == exp_rx[i], {tag, " R7 read byte"}, d, exp_rx[i]);
        end
    endtask

    task automatic build_write(input bit ack2);
        put_begin();
        put_wbyte(8'hA4, 4'd14);
        put_wbyte(8'h3C, 4'd14);
        put_finish();
        if (ack2) begin end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin : main
        bit pat[$];
        for (int i = 0; i < 64; i++) img[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 reset state
        chk(stat_o == 32'h8, "R4 status after reset", stat_o, 32'h8);
        chk(scl_o && sda_o, "R4 lines released", {scl_o, sda_o}, 2'b11);

        // T1: write two bytes, both acknowledged, even start nibble
        build_write(1'b1); load(32);
        pat.delete();
        for (int i = 0; i < 8; i++) pat.push_back(1'b1);
        pat.push_back(1'b0);
        for (int i = 0; i < 8; i++) pat.push_back(1'b1);
        pat.push_back(1'b0);
        set_slave(pat);
        run(32, -1, 1'b0, "write-ack");
        chk(exp_err == 2'b00, "R8 model no error expected", exp_err, 0);

        // T2: same program at odd nibble (R1), second byte not acknowledged
        build_write(1'b0); load(41);
        pat[17] = 1'b1;
        set_slave(pat);
        run(41, -1, 1'b0, "write-nack R1");
        chk(stat_o[2:1] == 2'b01, "R8 missing ack sets bit 1", stat_o[2:1], 2'b01);

        // T3: read two bytes 0x5A and 0xC3
        put_begin(); put_wbyte(8'hA1, 4'd14);
        put_rbyte(1'b0); put_rbyte(1'b1); put_finish();
        load(32);
        pat.delete();
        for (int i = 0; i < 8; i++) pat.push_back(1'b1);
        pat.push_back(1'b0);
        for (int i = 7; i >= 0; i--) pat.push_back(8'h5A >> i);
        pat.push_back(1'b1);
        for (int i = 7; i >= 0; i--) pat.push_back(8'hC3 >> i);
        pat.push_back(1'b1);
        set_slave(pat);
        run(32, -1, 1'b0, "read");
        chk(exp_rx.size() == 2 && exp_rx[0] == 8'h5A && exp_rx[1] == 8'hC3,
            "R7 model byte list", exp_rx.size(), 2);

        // T4: no-ops, pause, both acknowledge checks failing, odd start
        put(4'd1); put(4'd6); put_begin(); put(4'd7);
        put(4'd14); put(4'd15); put_finish();
        load(81);
        pat.delete(); pat.push_back(1'b1); pat.push_back(1'b0);
        set_slave(pat);
        run(81, -1, 1'b0, "nop-pause-acks R9");
        chk(stat_o[3:0] == 4'h6, "R8 both error bits", stat_o[3:0], 4'h6);

        // T5: start request during a run is ignored (R2)
        build_write(1'b1); load(32);
        pat.delete();
        for (int i = 0; i < 8; i++) pat.push_back(1'b1);
        pat.push_back(1'b0);
        for (int i = 0; i < 8; i++) pat.push_back(1'b1);
        pat.push_back(1'b0);
        set_slave(pat);
        run(32, 40, 1'b0, "restart-ignored R2");

        // T6: abort halfway through a read (R3)
        put_begin(); put_wbyte(8'hA1, 4'd14);
        put_rbyte(1'b1); put_finish();
        load(32);
        set_slave(pat);
        run(32, 60, 1'b1, "abort");
        @(negedge clk);
        chk(stat_o == 32'h8 && !stat_o[0], "R3 stays idle after abort", stat_o, 32'h8);

        // T7: clean run, then start and abort together: abort wins (R3)
        build_write(1'b1); load(32);
        set_slave(pat);
        run(32, -1, 1'b0, "pre-priority");
        chk(stat_o[3] == 1'b0, "R4 no-run bit cleared by start", stat_o[3], 0);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = 32'h0003_0000 | 32;
        @(negedge clk);
        ctl_we = 1'b0;
        chk(stat_o == 32'h8, "R3 abort beats start", stat_o, 32'h8);
        repeat (4) @(negedge clk);
        chk(stat_o == 32'h8 && scl_o && sda_o, "R3 no run after combined write",
            stat_o, 32'h8);

        summary();
        $finish;
    end
endmodule